// File: doc/BRIEF.md
# Effect Dispatch Table Unit

This block resolves an effect request into one of three outcomes by looking up a table of 256 entries of 32 bits. A request names its effect with a 4-bit family and a 4-bit op. The family is the upper half of the table index and the op is the lower half. Each table entry holds a 4-bit tag that picks the outcome:

- the effect traps;
- control jumps to a local handler address held in the entry;
- the effect becomes a 64-bit mesh packet for a remote tile. The entry supplies the packet's destination and device op. The request supplies the 32-bit payload.

Boot software fills the table through a one-cycle write port. Requests then arrive on a valid/ready handshake. The table is a synchronous RAM, so the lookup takes one clock cycle. The block holds exactly one outcome on a valid/ready output until it is taken, and it accepts no new request while that outcome is pending. The effect family 0xF is reserved for effects that hardware raises, so a request with that family always traps.

Top module: `effect_dispatch`

## Requirements
- R1: After reset, `reqReady` is 1 and `outValid` is 0.
- R2: Table write port:
  - A cycle with `wrEn` high stores `wrData` at index `wrIdx`.
  - A request with family F and op O reads the entry at index F*16+O.
  - The most recent write to an index decides the outcome of later requests.
- R3: An entry whose tag (bits [31:28]) is 0x0 or any value from 0x3 to 0xF gives `outKind` = 0 (trap), with `outPc` = 0 and `outPkt` = 0.
- R4: An entry with tag 0x1 gives `outKind` = 1 (local). `outPc` equals entry bits [19:0] and `outPkt` = 0.
- R5: An entry with tag 0x2 gives `outKind` = 2 (remote) and `outPc` = 0. The packet `outPkt` is laid out as follows; entry bits [27:26] and [19:6] have no effect on it:

  | Bits | Content |
  |---|---|
  | [5:0] | destination, from entry bits [5:0] |
  | [11:6] | parameter `SRC_TILE` |
  | [15:12] | packet op, from entry bits [23:20] (low 4 bits of the 6-bit device-op field [25:20]) |
  | [19:16] | flags, zero |
  | [51:20] | the request payload |
  | [63:52] | zero |

- R6: A request with family 0xF gives a trap outcome whatever its entry holds, with `outPc` = 0 and `outPkt` = 0.
- R7: Handshake timing:
  - A request is accepted on a clock edge where `reqValid` and `reqReady` are both 1.
  - `outValid` is 1 in the cycle after acceptance.
  - `reqReady` is 0 from that cycle until the edge where `outValid` and `outReady` are both 1. In the next cycle it is 1 and `outValid` is 0.
  - `reqValid` has no effect while `reqReady` is 0.
- R8: While `outValid` is 1 and `outReady` is 0, `outKind`, `outPc` and `outPkt` hold their values.
- R9: A table write to the requested index does not change that request's outcome. This holds for a write on the acceptance edge and for a write while the outcome is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Table write strobe |
| wrIdx | input | 8 | Table write index {family, op} |
| wrData | input | 32 | Table entry to store |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Unit can accept a request |
| reqFamily | input | 4 | Effect family |
| reqOp | input | 4 | Effect op |
| reqPayload | input | 32 | Effect payload value |
| outValid | output | 1 | Outcome valid |
| outReady | input | 1 | Downstream takes the outcome |
| outKind | output | 2 | 0 trap, 1 local, 2 remote |
| outPc | output | 20 | Local handler address |
| outPkt | output | 64 | Remote mesh packet |

## Verification
The bench builds the block with its default index widths, so all 256 table entries are in the sweep. It sets `SRC_TILE` to 0x2B, which puts bits in both halves of the source field. Every index receives an entry computed from its number. The tag takes every value from 0x0 to 0xF, the reserved and unused address bits vary, and each request carries a different payload. The trap, local and remote decodes, the field placement and the hardware-family rule are therefore all compared against arithmetic expectations. Directed sequences cover held outputs under backpressure, requests ignored while busy, and table writes that race a lookup.

// File: rtl/effect_dispatch_pkg.sv
package effect_dispatch_pkg;

  // Outcome codes driven on outKind
  typedef enum logic [1:0] {
    KIND_TRAP   = 2'd0,
    KIND_LOCAL  = 2'd1,
    KIND_REMOTE = 2'd2
  } outKind_e;

  // Tag values of a table entry; every other tag traps
  localparam logic [3:0] TAG_LOCAL  = 4'h1;
  localparam logic [3:0] TAG_REMOTE = 4'h2;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureReq;   // request accepted this edge: latch it and read the table
    logic releaseOut;   // outcome consumed this edge
  } ctrlStrobes_t;

endpackage

// File: rtl/effect_table_ram.sv
module effect_table_ram #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read returns the content from before a same-edge write
  always_ff @(posedge clk) begin
    if (rdEn) rdData <= mem[rdIdx];
    if (wrEn) mem[wrIdx] <= wrData;
  end
endmodule

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
  import effect_dispatch_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  output logic         reqReady,
  output logic         outValid,
  input  logic         outReady,
  output ctrlStrobes_t strobes
);
  typedef enum logic {ST_IDLE, ST_RESP} state_e;
  state_e state;

  assign reqReady           = (state == ST_IDLE);
  assign outValid           = (state == ST_RESP);
  assign strobes.captureReq = reqValid && reqReady;
  assign strobes.releaseOut = outValid && outReady;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (strobes.captureReq) state <= ST_RESP;
        ST_RESP: if (strobes.releaseOut) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: an accepted request yields an outcome on the next cycle
  a_r7_outcome_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> (outValid && !reqReady));

  // R7: a pending outcome is kept until taken
  a_r7_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid);

  // R7: consuming the outcome frees the unit
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady) |=> (reqReady && !outValid));
endmodule

// File: rtl/dispatch_datapath.sv
module dispatch_datapath
  import effect_dispatch_pkg::*;
#(
  parameter int              FAM_W     = 4,
  parameter int              OP_W      = 4,
  parameter int              PAYLOAD_W = 32,
  parameter int              TILE_W    = 6,
  parameter int              ENTRY_W   = 32,
  parameter int              ADDR_W    = 20,
  parameter int              OP2_W     = 6,
  parameter int              PKTOP_W   = 4,
  parameter int              FLAG_W    = 4,
  parameter int              PKT_W     = 64,
  parameter logic [TILE_W-1:0] SRC_TILE = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrlStrobes_t             strobes,
  input  logic                     outValid,
  input  logic                     outReady,
  input  logic [FAM_W-1:0]         reqFamily,
  input  logic [OP_W-1:0]          reqOp,
  input  logic [PAYLOAD_W-1:0]     reqPayload,
  output logic [FAM_W+OP_W-1:0]    rdIdx,
  input  logic [ENTRY_W-1:0]       rdData,
  output logic [1:0]               outKind,
  output logic [ADDR_W-1:0]        outPc,
  output logic [PKT_W-1:0]         outPkt
);
  // Entry layout
  localparam int TAG_W   = 4;
  localparam int TAG_LO  = ENTRY_W - TAG_W;
  localparam int OP2_LO  = ADDR_W;
  // Packet layout
  localparam int SRC_LO  = TILE_W;
  localparam int OPF_LO  = 2 * TILE_W;
  localparam int FLAG_LO = OPF_LO + PKTOP_W;
  localparam int PL_LO   = FLAG_LO + FLAG_W;

  logic [FAM_W-1:0]     capFamily;
  logic [PAYLOAD_W-1:0] capPayload;

  assign rdIdx = {reqFamily, reqOp};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capFamily  <= '0;
      capPayload <= '0;
    end else if (strobes.captureReq) begin
      capFamily  <= reqFamily;
      capPayload <= reqPayload;
    end
  end

  logic [TAG_W-1:0]  entryTag;
  logic [OP2_W-1:0]  entryOp2;
  logic [ADDR_W-1:0] entryAddr;
  logic              hwFamily;
  outKind_e          kindSel;
  logic [PKT_W-1:0]  remotePkt;

  assign entryTag  = rdData[TAG_LO +: TAG_W];
  assign entryOp2  = rdData[OP2_LO +: OP2_W];
  assign entryAddr = rdData[0 +: ADDR_W];
  assign hwFamily  = (capFamily == {FAM_W{1'b1}});

  always_comb begin
    if (hwFamily)                      kindSel = KIND_TRAP;
    else if (entryTag == TAG_LOCAL)    kindSel = KIND_LOCAL;
    else if (entryTag == TAG_REMOTE)   kindSel = KIND_REMOTE;
    else                               kindSel = KIND_TRAP;
  end

  always_comb begin
    remotePkt = '0;
    remotePkt[0 +: TILE_W]         = entryAddr[TILE_W-1:0];
    remotePkt[SRC_LO +: TILE_W]    = SRC_TILE;
    remotePkt[OPF_LO +: PKTOP_W]   = entryOp2[PKTOP_W-1:0];
    remotePkt[FLAG_LO +: FLAG_W]   = '0;
    remotePkt[PL_LO +: PAYLOAD_W]  = capPayload;
  end

  assign outKind = kindSel;
  assign outPc   = (kindSel == KIND_LOCAL)  ? entryAddr : '0;
  assign outPkt  = (kindSel == KIND_REMOTE) ? remotePkt : '0;

  // R6: hardware-only family never leaves as local or remote
  a_r6_hw_family_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && capFamily == {FAM_W{1'b1}}) |-> (outKind == KIND_TRAP));

  // R3: a trap carries no address and no packet
  a_r3_trap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outKind == KIND_TRAP) |-> (outPc == '0 && outPkt == '0));

  // R8: outcome held steady under backpressure
  a_r8_stable_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> ($stable(outKind) && $stable(outPc) && $stable(outPkt)));

  // R5: remote payload field is the captured request payload
  a_r5_payload_field: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outKind == KIND_REMOTE) |-> (outPkt[PL_LO +: PAYLOAD_W] == capPayload));
endmodule

// File: rtl/effect_dispatch.sv
module effect_dispatch
  import effect_dispatch_pkg::*;
#(
  parameter int                FAM_W     = 4,
  parameter int                OP_W      = 4,
  parameter int                PAYLOAD_W = 32,
  parameter int                TILE_W    = 6,
  parameter int                ENTRY_W   = 32,
  parameter int                ADDR_W    = 20,
  parameter int                PKT_W     = 64,
  parameter logic [TILE_W-1:0] SRC_TILE  = 6'h01
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wrEn,
  input  logic [FAM_W+OP_W-1:0]  wrIdx,
  input  logic [ENTRY_W-1:0]     wrData,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [FAM_W-1:0]       reqFamily,
  input  logic [OP_W-1:0]        reqOp,
  input  logic [PAYLOAD_W-1:0]   reqPayload,
  output logic                   outValid,
  input  logic                   outReady,
  output logic [1:0]             outKind,
  output logic [ADDR_W-1:0]      outPc,
  output logic [PKT_W-1:0]       outPkt
);
  localparam int IDX_W = FAM_W + OP_W;

  ctrlStrobes_t       strobes;
  logic [IDX_W-1:0]   rdIdx;
  logic [ENTRY_W-1:0] rdData;

  dispatch_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .outValid (outValid),
    .outReady (outReady),
    .strobes  (strobes)
  );

  effect_table_ram #(.IDX_W(IDX_W), .DATA_W(ENTRY_W)) u_table (
    .clk    (clk),
    .wrEn   (wrEn),
    .wrIdx  (wrIdx),
    .wrData (wrData),
    .rdEn   (strobes.captureReq),
    .rdIdx  (rdIdx),
    .rdData (rdData)
  );

  dispatch_datapath #(
    .FAM_W(FAM_W), .OP_W(OP_W), .PAYLOAD_W(PAYLOAD_W), .TILE_W(TILE_W),
    .ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W), .PKT_W(PKT_W), .SRC_TILE(SRC_TILE)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .outValid   (outValid),
    .outReady   (outReady),
    .reqFamily  (reqFamily),
    .reqOp      (reqOp),
    .reqPayload (reqPayload),
    .rdIdx      (rdIdx),
    .rdData     (rdData),
    .outKind    (outKind),
    .outPc      (outPc),
    .outPkt     (outPkt)
  );
endmodule

// File: tb/test_effect_dispatch.sv
module test_effect_dispatch;
  localparam logic [5:0] SRC = 6'h2B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [3:0]  reqFamily = '0;
  logic [3:0]  reqOp = '0;
  logic [31:0] reqPayload = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [1:0]  outKind;
  logic [19:0] outPc;
  logic [63:0] outPkt;

  int nCmp = 0;
  int nBad = 0;

  always #2 clk = ~clk;   // 250 MHz

  effect_dispatch #(.SRC_TILE(SRC)) i_effect_dispatch (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqFamily(reqFamily),
    .reqOp(reqOp), .reqPayload(reqPayload), .outValid(outValid),
    .outReady(outReady), .outKind(outKind), .outPc(outPc), .outPkt(outPkt)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] entryFor(input int i);
    logic [31:0] h;
    logic [3:0]  tag;
    h   = 32'(i) * 32'h9E3779B1 + 32'h1234567;
    tag = 4'((i * 7 + i / 16) % 16);
    return {tag, h[27:0]};
  endfunction

  function automatic logic [31:0] payloadFor(input int i);
    return 32'(i + 1) * 32'h7FEB352D ^ 32'hA5A55A5A;
  endfunction

  // Compare the presented outcome with the value the requirements dictate
  task automatic checkOutcome(input logic [31:0] e, input logic [3:0] fam,
                              input logic [31:0] pl, input string ctx);
    logic [1:0]  eKind;
    logic [19:0] ePc;
    logic [63:0] ePkt;
    eKind = 2'd0; ePc = '0; ePkt = '0;
    if (fam != 4'hF && e[31:28] == 4'h1) begin
      eKind = 2'd1; ePc = e[19:0];
    end else if (fam != 4'hF && e[31:28] == 4'h2) begin
      eKind = 2'd2;
      ePkt = {12'h000, pl, 4'h0, e[23:20], SRC, e[5:0]};
    end
    chk(outKind == eKind, {ctx, " R3/R4/R5/R6 kind"}, 64'(outKind), 64'(eKind));
    chk(outPc == ePc, {ctx, " R4 pc"}, 64'(outPc), 64'(ePc));
    chk(outPkt == ePkt, {ctx, " R5 packet"}, outPkt, ePkt);
  endtask

  task automatic writeEntry(input logic [7:0] idx, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Issue one request with outReady high; check the outcome the cycle after acceptance
  task automatic doReq(input logic [7:0] idx, input logic [31:0] pl,
                       input logic [31:0] e, input string ctx);
    @(negedge clk);
    reqValid = 1'b1; reqFamily = idx[7:4]; reqOp = idx[3:0]; reqPayload = pl;
    outReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(outValid && !reqReady, {ctx, " R7 outcome next cycle"}, 64'({outValid, reqReady}), 64'h2);
    checkOutcome(e, idx[7:4], pl, ctx);
  endtask

  initial begin
    logic [31:0] oldE;
    logic [1:0]  hKind;
    logic [19:0] hPc;
    logic [63:0] hPkt;

    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1 && outValid == 1'b0, "R1 reset state", 64'({reqReady, outValid}), 64'h2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && outValid == 1'b0, "R1 after reset release", 64'({reqReady, outValid}), 64'h2);

    // R2 fill every index, then sweep all of them (R3 R4 R5 R6)
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrIdx = 8'(i); wrData = entryFor(i);
    end
    @(negedge clk);
    wrEn = 1'b0;
    for (int i = 0; i < 256; i++) doReq(8'(i), payloadFor(i), entryFor(i), "R2 sweep");

    // R6: hardware family traps even with a local entry
    writeEntry(8'hF3, 32'h1000_ABCD);
    doReq(8'hF3, 32'h1, 32'h1000_ABCD, "R6 hw family local entry");
    writeEntry(8'hF7, 32'h2FFF_FFFF);
    doReq(8'hF7, 32'hFFFF_FFFF, 32'h2FFF_FFFF, "R6 hw family remote entry");

    // R5: all-ones payload with reserved and upper address bits set
    writeEntry(8'h21, 32'h2C5F_FFC0 | 32'h10);
    doReq(8'h21, 32'hFFFF_FFFF, 32'h2C5F_FFD0, "R5 remote ones");

    // R8 / R7 / R9: backpressure with a busy-time request and a racing write
    @(negedge clk);
    outReady = 1'b0;
    reqValid = 1'b1; reqFamily = 4'h3; reqOp = 4'h4; reqPayload = 32'hCAFE_0001;
    oldE = entryFor(8'h34);
    @(negedge clk);
    reqFamily = 4'h1; reqOp = 4'h2; reqPayload = 32'h0;   // must be ignored (R7)
    wrEn = 1'b1; wrIdx = 8'h34; wrData = 32'h1000_0777; // pending index rewritten (R9)
    checkOutcome(oldE, 4'h3, 32'hCAFE_0001, "R8 first cycle");
    hKind = outKind; hPc = outPc; hPkt = outPkt;
    @(negedge clk);
    wrEn = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(outValid && !reqReady, "R7 held while busy", 64'({outValid, reqReady}), 64'h2);
      chk(outKind == hKind && outPc == hPc && outPkt == hPkt, "R8 stable outputs", outPkt, hPkt);
      checkOutcome(oldE, 4'h3, 32'hCAFE_0001, "R9 pending write ignored");
      @(negedge clk);
    end
    outReady = 1'b1;
    reqValid = 1'b0;
    @(negedge clk);
    chk(reqReady && !outValid, "R7 released after take", 64'({reqReady, outValid}), 64'h2);

    // R2: last write wins for later requests
    doReq(8'h34, 32'h5, 32'h1000_0777, "R2 rewritten entry");

    // R9: write on the acceptance edge does not affect that lookup
    writeEntry(8'h56, 32'h2000_0011);
    @(negedge clk);
    reqValid = 1'b1; reqFamily = 4'h5; reqOp = 4'h6; reqPayload = 32'h0BAD_F00D;
    wrEn = 1'b1; wrIdx = 8'h56; wrData = 32'h1000_0022;
    @(negedge clk);
    reqValid = 1'b0; wrEn = 1'b0;
    checkOutcome(32'h2000_0011, 4'h5, 32'h0BAD_F00D, "R9 same-edge write");
    doReq(8'h56, 32'h0, 32'h1000_0022, "R2 after same-edge write");

    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule